// File: doc/BRIEF.md
# IO port permission checker

This unit decides, for one IO instruction at a time, whether the current task may touch the addressed IO ports or must take a general-protection fault. A request carries the task's current privilege level, the IO privilege level, the virtual-8086 mode flag, a 16-bit port number and an access size. When the privilege comparison is enough, the unit answers at once. When the privilege comparison fails, or in virtual-8086 mode, the unit reads the task's per-port permission bitmap through a synchronous byte-wide memory port and answers from it.

The bitmap holds one bit per port. A bit value of 0 permits the port and a bit value of 1 denies it. The bit for port `p` sits at byte address `map_base + p/8`, bit `p%8`. An access covers 1, 2 or 4 consecutive ports and may straddle two bitmap bytes. In that case both bytes are read, one after the other. A byte address above `map_limit` counts as a denial. Each verdict leaves as a one-cycle `done` pulse with exactly one of `grant` or `fault` set.

The controller has five named states:
- IDLE waits for a request.
- FETCH_LO drives the read of the first bitmap byte.
- CHECK_LO judges that byte and, if the access spans two bytes, drives the read of the second.
- CHECK_HI judges the second byte.
- REPORT pulses the verdict.

The transitions are:
- IDLE→REPORT on a decided request, which is a privilege pass, a bad size code or a byte out of range.
- IDLE→FETCH_LO on any other request.
- FETCH_LO→CHECK_LO always.
- CHECK_LO→CHECK_HI when the access spans two bytes.
- CHECK_LO→REPORT otherwise.
- CHECK_HI→REPORT always.
- REPORT→IDLE always.

Top module: `io_perm_chk`

## Requirements
- R1: After reset the unit is idle: `busy`, `done`, `grant`, `fault` and `mem_rd_en` are all 0.
- R2: With `req_v86`=0 and `req_cpl` <= `req_iopl` (numerically), a valid size is granted with no bitmap read, and `done` rises in the cycle after acceptance.
- R3: With `req_v86`=0 and `req_cpl` > `req_iopl`, the bitmap decides. Port `p` is read at byte `map_base + p/8`, bit `p%8`, and a bit of 0 permits while a bit of 1 denies.
- R4: With `req_v86`=1, `req_iopl` is ignored and the bitmap is always consulted, even when `req_cpl` <= `req_iopl`.
- R5: `req_size` 0, 1 and 2 cover 1, 2 and 4 consecutive ports starting at `req_port`. The access is granted only if every covered bit is 0.
- R6: An access whose ports span two bitmap bytes reads byte `a`, then byte `a+1`, in consecutive cycles, and judges both.
- R7: If any required bitmap byte address exceeds `map_limit`, the access faults without any bitmap read.
- R8: `req_size`=3 is reserved and always faults without a bitmap read, whatever the privilege levels.
- R9: `done` is a single-cycle pulse. While it is high, exactly one of `grant` and `fault` is high, and both are low whenever `done` is low.
- R10: A request is accepted only in IDLE. A request raised while `busy` is high, including during the `done` cycle, is ignored and produces no verdict.
- R11: Latency from the accepting edge to `done` is 1 cycle on the decided path, 3 cycles for a one-byte lookup and 4 cycles for a two-byte lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_cpl | input | 2 | Current privilege level |
| req_iopl | input | 2 | IO privilege level |
| req_v86 | input | 1 | Virtual-8086 mode flag |
| req_port | input | 16 | First port number |
| req_size | input | 2 | 0: 1 port, 1: 2 ports, 2: 4 ports, 3: reserved |
| map_base | input | 16 | Byte address of bitmap byte 0 |
| map_limit | input | 16 | Highest valid bitmap byte address |
| mem_rd_en | output | 1 | Bitmap read enable |
| mem_rd_addr | output | 16 | Bitmap byte address |
| mem_rd_data | input | 8 | Read data, valid one cycle after `mem_rd_en` |
| busy | output | 1 | Unit not idle |
| done | output | 1 | Verdict pulse |
| grant | output | 1 | Access allowed (with `done`) |
| fault | output | 1 | General-protection fault (with `done`) |

## Verification
Two things can fall in the same cycle: the REPORT pulse of one verdict and a fresh request strobe. The bench holds `req_valid` high from the cycle after an accepted two-byte lookup through the verdict cycle, then drops it. The run is judged correct only if exactly one `done` pulse appears, it carries the first request's verdict, and no second pulse follows. A second overlap is a privilege pass and a bitmap lookup in the same cycle, which happens in virtual-8086 mode with `req_cpl` <= `req_iopl`. There the bench demands the bitmap latency and read count, not the one-cycle grant.

// File: rtl/io_perm_pkg.sv
package io_perm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_FETCH_LO = 3'd1,
        ST_CHECK_LO = 3'd2,
        ST_CHECK_HI = 3'd3,
        ST_REPORT   = 3'd4
    } perm_state_e;

    localparam logic [1:0] SZ_ONE  = 2'd0;
    localparam logic [1:0] SZ_TWO  = 2'd1;
    localparam logic [1:0] SZ_FOUR = 2'd2;
    localparam logic [1:0] SZ_RSVD = 2'd3;

endpackage

// File: rtl/io_perm_decode.sv
module io_perm_decode #(
    parameter int PRIV_W = 2,
    parameter int PORT_W = 16,
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [PRIV_W-1:0] cpl,
    input  logic [PRIV_W-1:0] iopl,
    input  logic              v86,
    input  logic [PORT_W-1:0] port,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    output logic              fast_path,
    output logic              fast_deny,
    output logic              span,
    output logic [ADDR_W-1:0] addr_lo,
    output logic [ADDR_W-1:0] addr_hi,
    output logic [BYTE_W-1:0] mask_lo,
    output logic [BYTE_W-1:0] mask_hi
);
    import io_perm_pkg::*;

    localparam int BIT_IDX_W = $clog2(BYTE_W);
    localparam int MASK_W    = 2 * BYTE_W;
    localparam int WIDE_W    = ADDR_W + 1;

    logic                 priv_pass;
    logic                 size_bad;
    logic                 out_of_range;
    logic [3:0]           run_bits;
    logic [MASK_W-1:0]    run_mask;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic [WIDE_W-1:0]    wide_lo;
    logic [WIDE_W-1:0]    wide_hi;
    logic [WIDE_W-1:0]    wide_lim;

    assign bit_idx   = port[BIT_IDX_W-1:0];
    assign priv_pass = !v86 && (cpl <= iopl);
    assign size_bad  = (size == SZ_RSVD);

    always_comb begin
        unique case (size)
            SZ_ONE:  run_bits = 4'b0001;
            SZ_TWO:  run_bits = 4'b0011;
            SZ_FOUR: run_bits = 4'b1111;
            default: run_bits = 4'b0000;
        endcase
    end

    assign run_mask = MASK_W'(run_bits) << bit_idx;
    assign mask_lo  = run_mask[BYTE_W-1:0];
    assign mask_hi  = run_mask[MASK_W-1:BYTE_W];
    assign span     = |mask_hi;

    assign wide_lo  = WIDE_W'(base) + WIDE_W'(port >> BIT_IDX_W);
    assign wide_hi  = wide_lo + WIDE_W'(1);
    assign wide_lim = WIDE_W'(limit);

    assign out_of_range = (wide_lo > wide_lim) || (span && (wide_hi > wide_lim));

    assign addr_lo = wide_lo[ADDR_W-1:0];
    assign addr_hi = wide_hi[ADDR_W-1:0];

    assign fast_path = size_bad || priv_pass || out_of_range;
    assign fast_deny = size_bad || (!priv_pass && out_of_range);

endmodule

// File: rtl/io_perm_eval.sv
module io_perm_eval #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] map_byte,
    input  logic [BYTE_W-1:0] mask,
    output logic              deny
);
    logic [BYTE_W-1:0] hit;

    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        assign hit[i] = map_byte[i] & mask[i];
    end

    assign deny = |hit;

endmodule

// File: rtl/io_perm_fsm.sv
module io_perm_fsm #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              fast_path,
    input  logic              fast_deny,
    input  logic              span,
    input  logic [ADDR_W-1:0] addr_lo,
    input  logic [ADDR_W-1:0] addr_hi,
    input  logic [BYTE_W-1:0] mask_lo,
    input  logic [BYTE_W-1:0] mask_hi,
    input  logic              byte_deny,
    output logic [BYTE_W-1:0] cur_mask,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              done,
    output logic              grant,
    output logic              fault
);
    import io_perm_pkg::*;

    perm_state_e       state, nxt;
    logic              accept;
    logic              span_q;
    logic              deny_q;
    logic [ADDR_W-1:0] addr_lo_q;
    logic [ADDR_W-1:0] addr_hi_q;
    logic [BYTE_W-1:0] mask_lo_q;
    logic [BYTE_W-1:0] mask_hi_q;

    assign accept = req_valid && (state == ST_IDLE);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (accept) nxt = fast_path ? ST_REPORT : ST_FETCH_LO;
            ST_FETCH_LO: nxt = ST_CHECK_LO;
            ST_CHECK_LO: nxt = span_q ? ST_CHECK_HI : ST_REPORT;
            ST_CHECK_HI: nxt = ST_REPORT;
            ST_REPORT:   nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            span_q    <= 1'b0;
            deny_q    <= 1'b0;
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            mask_lo_q <= '0;
            mask_hi_q <= '0;
        end else if (accept) begin
            span_q    <= span;
            deny_q    <= fast_path && fast_deny;
            addr_lo_q <= addr_lo;
            addr_hi_q <= addr_hi;
            mask_lo_q <= mask_lo;
            mask_hi_q <= mask_hi;
        end else if ((state == ST_CHECK_LO) || (state == ST_CHECK_HI)) begin
            deny_q <= deny_q | byte_deny;
        end
    end

    always_comb begin
        rd_en    = 1'b0;
        rd_addr  = addr_lo_q;
        cur_mask = mask_lo_q;
        done     = 1'b0;
        grant    = 1'b0;
        fault    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_FETCH_LO: rd_en = 1'b1;
            ST_CHECK_LO: begin
                rd_en   = span_q;
                rd_addr = addr_hi_q;
            end
            ST_CHECK_HI: cur_mask = mask_hi_q;
            ST_REPORT: begin
                done  = 1'b1;
                grant = !deny_q;
                fault = deny_q;
            end
            default: ;
        endcase
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/io_perm_chk.sv
module io_perm_chk #(
    parameter int PRIV_W = 2,
    parameter int PORT_W = 16,
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PRIV_W-1:0] req_cpl,
    input  logic [PRIV_W-1:0] req_iopl,
    input  logic              req_v86,
    input  logic [PORT_W-1:0] req_port,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] map_base,
    input  logic [ADDR_W-1:0] map_limit,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [BYTE_W-1:0] mem_rd_data,
    output logic              busy,
    output logic              done,
    output logic              grant,
    output logic              fault
);
    logic              fast_path, fast_deny, span, byte_deny;
    logic [ADDR_W-1:0] addr_lo, addr_hi;
    logic [BYTE_W-1:0] mask_lo, mask_hi, cur_mask;

    io_perm_decode #(
        .PRIV_W(PRIV_W), .PORT_W(PORT_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)
    ) u_decode (
        .cpl(req_cpl), .iopl(req_iopl), .v86(req_v86), .port(req_port),
        .size(req_size), .base(map_base), .limit(map_limit),
        .fast_path(fast_path), .fast_deny(fast_deny), .span(span),
        .addr_lo(addr_lo), .addr_hi(addr_hi),
        .mask_lo(mask_lo), .mask_hi(mask_hi)
    );

    io_perm_eval #(.BYTE_W(BYTE_W)) u_eval (
        .map_byte(mem_rd_data), .mask(cur_mask), .deny(byte_deny)
    );

    io_perm_fsm #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .fast_path(fast_path), .fast_deny(fast_deny), .span(span),
        .addr_lo(addr_lo), .addr_hi(addr_hi),
        .mask_lo(mask_lo), .mask_hi(mask_hi), .byte_deny(byte_deny),
        .cur_mask(cur_mask), .rd_en(mem_rd_en), .rd_addr(mem_rd_addr),
        .busy(busy), .done(done), .grant(grant), .fault(fault)
    );

endmodule

// File: rtl/io_perm_chk_sva.sv
module io_perm_chk_sva #(
    parameter int PRIV_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [PRIV_W-1:0] req_cpl,
    input logic [PRIV_W-1:0] req_iopl,
    input logic              req_v86,
    input logic [1:0]        req_size,
    input logic              mem_rd_en,
    input logic              busy,
    input logic              done,
    input logic              grant,
    input logic              fault
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    verdict_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (grant ^ fault));

    // R9
    verdict_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!grant && !fault));

    // R2
    priv_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_v86 && (req_cpl <= req_iopl) && (req_size != 2'd3))
        |=> (done && grant && !mem_rd_en));

    // R8
    rsvd_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && (req_size == 2'd3)) |=> (done && fault && !mem_rd_en));

    // R10
    read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (busy && !done));
endmodule

bind io_perm_chk io_perm_chk_sva #(.PRIV_W(PRIV_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cpl(req_cpl),
    .req_iopl(req_iopl), .req_v86(req_v86), .req_size(req_size),
    .mem_rd_en(mem_rd_en), .busy(busy), .done(done), .grant(grant), .fault(fault)
);

// File: tb/sim_io_perm_chk.sv
`timescale 1ns/1ps
module sim_io_perm_chk;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_cpl = '0, req_iopl = '0, req_size = '0;
    logic        req_v86 = 1'b0;
    logic [15:0] req_port = '0;
    logic [15:0] map_base = 16'h0100;
    logic [15:0] map_limit = 16'h0120;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [7:0]  mem_rd_data = '0;
    logic        busy, done, grant, fault;

    logic [7:0]  mem [0:1023];
    int          rd_cnt = 0;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    io_perm_chk u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cpl(req_cpl),
        .req_iopl(req_iopl), .req_v86(req_v86), .req_port(req_port),
        .req_size(req_size), .map_base(map_base), .map_limit(map_limit),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .busy(busy), .done(done), .grant(grant), .fault(fault)
    );

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem[mem_rd_addr[9:0]];
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit ref_grant(input bit v86, input int cpl, input int iopl,
                                     input int port, input int size);
        int n;
        if (size == 3) return 1'b0;
        if (!v86 && cpl <= iopl) return 1'b1;
        n = (size == 0) ? 1 : (size == 1) ? 2 : 4;
        for (int i = 0; i < n; i++) begin
            int p = port + i;
            int a = int'(map_base) + p / 8;
            if (a > int'(map_limit)) return 1'b0;
            if (mem[a % 1024][p % 8]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic run_req(input string req, input bit v86, input int cpl, input int iopl,
                           input int port, input int size, input int exp_lat,
                           input int exp_rd);
        bit exp_g;
        int lat, r0;
        exp_g = ref_grant(v86, cpl, iopl, port, size);
        @(negedge clk);
        req_v86 = v86; req_cpl = 2'(cpl); req_iopl = 2'(iopl);
        req_port = 16'(port); req_size = 2'(size); req_valid = 1'b1;
        r0 = rd_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(done == 1'b1, req, "done seen", int'(done), 1);
        check(grant == exp_g && fault == !exp_g, req, "grant", int'(grant), int'(exp_g));
        check(lat == exp_lat, {req, "/R11"}, "latency", lat, exp_lat);
        check(rd_cnt - r0 == exp_rd, req, "bitmap reads", rd_cnt - r0, exp_rd);
        @(negedge clk);
        check(!done && !grant && !fault, "R9", "pulse width", int'(done), 0);
    endtask

    task automatic t_reset();
        check(!busy && !done && !grant && !fault && !mem_rd_en, "R1", "idle after reset",
              int'({busy, done, grant, fault, mem_rd_en}), 0);
    endtask

    task automatic t_priv();
        run_req("R2", 0, 0, 0, 16'h03F8, 0, 1, 0);
        run_req("R2", 0, 2, 3, 16'h0010, 2, 1, 0);
    endtask

    task automatic t_bitmap();
        run_req("R3", 0, 3, 0, 16'h0010, 0, 3, 1);
        run_req("R3", 0, 3, 0, 16'h0011, 0, 3, 1);
    endtask

    task automatic t_v86();
        run_req("R4", 1, 0, 3, 16'h0010, 0, 3, 1);
        run_req("R4", 1, 0, 3, 16'h0011, 0, 3, 1);
    endtask

    task automatic t_multi();
        run_req("R5", 0, 3, 1, 16'h001C, 2, 3, 1);
        run_req("R5", 0, 3, 1, 16'h001A, 2, 3, 1);
        run_req("R5", 1, 0, 0, 16'h0012, 1, 3, 1);
    endtask

    task automatic t_span();
        run_req("R6", 0, 3, 0, 16'h001E, 2, 4, 2);
        run_req("R6", 0, 3, 0, 16'h001F, 1, 4, 2);
        run_req("R6", 1, 3, 0, 16'h001F, 2, 4, 2);
    endtask

    task automatic t_limit();
        run_req("R7", 0, 3, 0, 16'h0108, 0, 1, 0);
        run_req("R7", 0, 3, 0, 16'h0107, 1, 1, 0);
        run_req("R7", 0, 3, 0, 16'h0100, 2, 3, 1);
    endtask

    task automatic t_rsvd();
        run_req("R8", 0, 0, 3, 16'h0010, 3, 1, 0);
    endtask

    task automatic t_busy();
        int lat, dones, r0;
        bit exp_g;
        exp_g = ref_grant(0, 3, 0, 16'h001E, 2);
        @(negedge clk);
        req_v86 = 0; req_cpl = 2'd3; req_iopl = 2'd0;
        req_port = 16'h001E; req_size = 2'd2; req_valid = 1'b1;
        r0 = rd_cnt;
        @(negedge clk);
        req_cpl = 2'd0; req_port = 16'h0108; req_size = 2'd3;
        lat = 1; dones = 0;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(done && grant == exp_g, "R10", "first verdict kept", int'(grant), int'(exp_g));
        check(lat == 4, "R10", "latency under busy strobe", lat, 4);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 5; i++) begin
            if (done) dones++;
            @(negedge clk);
        end
        check(dones == 0, "R10", "extra verdicts", dones, 0);
        check(rd_cnt - r0 == 2, "R10", "bitmap reads", rd_cnt - r0, 2);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        mem[16'h102 % 1024] = 8'hFE;
        mem[16'h103 % 1024] = 8'h0F;
        mem[16'h104 % 1024] = 8'hFC;
        mem[16'h120 % 1024] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_priv();
        t_bitmap();
        t_v86();
        t_multi();
        t_span();
        t_limit();
        t_rsvd();
        t_busy();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule